// File: doc/BRIEF.md
# SPI Data-Register FIFO Front-End

This block connects a 32-bit register bus to the shift engine of an SPI master through two FIFOs. A host write to the transmit data register places one or two data items into the transmit FIFO. A host read of the receive data register removes one to four items from the receive FIFO. The shift engine takes transmit items through a valid/pop stream and returns received items, each tagged with the chip-select of its transfer, through a push stream.

The item width can be set anywhere from 8 to 16 bits, and both FIFO depths are counted in items. The number of items that one access moves depends on the packing mode of each direction, the byte strobes of the access and the item width. When master mode is set, receive packing is always off, because every single-item read also carries the chip-select field. Overrun and underrun are sticky flags that only reset clears. The item counts of both FIFOs are status outputs.

Top module: `spi_fifo_front`

## Requirements
- R1: The item width is `cfg_width`, limited to the range 8..16: any value below 8 acts as 8 and any value above 16 acts as 16. Each item is masked to this width when it enters either FIFO.
- R2: Transmit packing is off when `tx_multi`=0. Each write with at least one strobe set then pushes the single item in `wr_data[15:0]`. A write or read with `wr_strb`/`rd_strb` equal to 0, or a `tx_pop` while the transmit FIFO is empty, changes no level and no flag.
- R3: With `tx_multi`=1, a write with `wr_strb`=4'b1111 pushes two items, `wr_data[15:0]` first and `wr_data[31:16]` second. Any other nonzero strobe pattern pushes one item from `wr_data[15:0]`.
- R4: A write is accepted only when the transmit FIFO has room for every item the write carries, judged on the level before that cycle. A rejected write pushes nothing and sets the sticky `overrun` flag.
- R5: `tx_valid` is high while the transmit FIFO holds at least one item. `tx_item` shows the oldest item, and `tx_pop` removes it, so items leave in the order they were pushed.
- R6: When receive packing is off, a read returns the oldest item in `rd_data[15:0]` and its chip-select in `rd_data[16+CSW-1:16]` (bits 19:16 by default), with all upper bits zero, and removes one item. `rd_data` is registered and is valid in the cycle after the read.
- R7: Receive packing is in effect only when `rx_multi`=1 and `master`=0. With `master`=1, every read behaves as described in R6.
- R8: With receive packing on and an item width of 8 or less, a read asks for n items, where n is the index of the highest strobed byte plus one. Item k goes to byte k of `rd_data`, and the other bytes are zero.
- R9: With receive packing on and an item width above 8, a read asks for two items if `rd_strb[3]` or `rd_strb[2]` is set, and one item otherwise. Item k goes to `rd_data[16k+15:16k]`.
- R10: When a read asks for more items than the receive FIFO holds, it returns and removes the items that are there, leaves the missing lanes zero and sets the sticky `underrun` flag. A single-item read of an empty FIFO returns zero.
- R11: A `rx_push` while the receive FIFO holds DEPTH items drops the item and sets `overrun`.
- R12: `tx_level` and `rx_level` count items, not bytes, up to DEPTH at any width. A push and a pop in the same cycle leave the level unchanged.
- R13: After reset both levels, `tx_valid`, `rd_data`, `overrun` and `underrun` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 5 | Item width in bits, limited to 8..16 |
| tx_multi | input | 1 | Transmit packing enable |
| rx_multi | input | 1 | Receive packing request |
| master | input | 1 | Master mode; forces receive packing off |
| wr_en | input | 1 | Host write to the transmit data register |
| wr_strb | input | 4 | Byte strobes of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Host read of the receive data register |
| rd_strb | input | 4 | Byte strobes of the read |
| rd_data | output | 32 | Read data, registered |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_item | output | 16 | Oldest transmit item |
| tx_pop | input | 1 | Shift engine takes the oldest transmit item |
| rx_push | input | 1 | Shift engine delivers a received item |
| rx_item | input | 16 | Received item |
| rx_cs | input | CSW | Chip-select of the received item |
| tx_level | output | clog2(DEPTH+1) | Transmit FIFO item count |
| rx_level | output | clog2(DEPTH+1) | Receive FIFO item count |
| overrun | output | 1 | Sticky: a write was rejected or a received item was dropped |
| underrun | output | 1 | Sticky: a read found fewer items than it asked for |

## Verification
The bench builds the block with DEPTH=4 and CSW=4. A depth of four lets a few writes fill the transmit FIFO. It also lets the bench reach the case where a two-item write arrives with only one slot free, and reach the receive full-drop case with a short stream. A four-item packed read can empty the whole receive FIFO in one access. With the 4-bit chip-select, the field appears in bits 19:16. Item widths of 8, 12 and 16 are used, together with values outside the legal range, to cover the byte-lane and half-word packing and the width masking.

// File: rtl/spi_fifo_front.sv
module spi_fifo_front #(
  parameter int DEPTH = 32,
  parameter int CSW   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [4:0]                   cfg_width,
  input  logic                         tx_multi,
  input  logic                         rx_multi,
  input  logic                         master,
  input  logic                         wr_en,
  input  logic [3:0]                   wr_strb,
  input  logic [31:0]                  wr_data,
  input  logic                         rd_en,
  input  logic [3:0]                   rd_strb,
  output logic [31:0]                  rd_data,
  output logic                         tx_valid,
  output logic [15:0]                  tx_item,
  input  logic                         tx_pop,
  input  logic                         rx_push,
  input  logic [15:0]                  rx_item,
  input  logic [CSW-1:0]               rx_cs,
  output logic [$clog2(DEPTH+1)-1:0]   tx_level,
  output logic [$clog2(DEPTH+1)-1:0]   rx_level,
  output logic                         overrun,
  output logic                         underrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);
  localparam int EW = 16 + CSW;

  logic [4:0]  wid;
  logic [15:0] mask;
  assign wid  = (cfg_width < 5'd8) ? 5'd8 : (cfg_width > 5'd16) ? 5'd16 : cfg_width;
  assign mask = 16'hFFFF >> (5'd16 - wid);

  // transmit side
  logic [15:0]   tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [LW-1:0] tx_cnt;

  wire          tx_two  = tx_multi && (wr_strb == 4'hF);
  wire [LW-1:0] tx_n    = tx_two ? LW'(2) : LW'(1);
  wire          tx_wr   = wr_en && (wr_strb != 4'h0);
  wire          tx_fit  = (int'(tx_cnt) + int'(tx_n)) <= DEPTH;
  wire          tx_acc  = tx_wr && tx_fit;
  wire          tx_take = tx_pop && (tx_cnt != '0);

  always_ff @(posedge clk)
    if (tx_acc) begin
      tx_mem[tx_wp] <= wr_data[15:0] & mask;
      if (tx_two) tx_mem[tx_wp + AW'(1)] <= wr_data[31:16] & mask;
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_acc)  tx_wp <= tx_wp + (tx_two ? AW'(2) : AW'(1));
      if (tx_take) tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + (tx_acc ? tx_n : LW'(0)) - (tx_take ? LW'(1) : LW'(0));
    end

  assign tx_valid = (tx_cnt != '0);
  assign tx_item  = tx_mem[tx_rp];
  assign tx_level = tx_cnt;

  // receive side
  logic [EW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [LW-1:0] rx_cnt;
  logic [2:0]    rx_req, rx_got;
  logic [31:0]   rd_next;

  wire rx_packed = rx_multi && !master;
  wire narrow    = (wid <= 5'd8);
  wire rx_rd     = rd_en && (rd_strb != 4'h0);
  wire rx_ok     = rx_push && (rx_cnt != LW'(DEPTH));

  always_comb begin
    if (!rx_packed)   rx_req = 3'd1;
    else if (narrow)  rx_req = rd_strb[3] ? 3'd4 : rd_strb[2] ? 3'd3 : rd_strb[1] ? 3'd2 : 3'd1;
    else              rx_req = (rd_strb[3] | rd_strb[2]) ? 3'd2 : 3'd1;
    rx_got = (int'(rx_cnt) < int'(rx_req)) ? 3'(rx_cnt) : rx_req;
  end

  always_comb begin
    rd_next = '0;
    if (!rx_packed) begin
      if (rx_cnt != '0) rd_next = 32'(rx_mem[rx_rp]);
    end else begin
      for (int k = 0; k < 4; k++)
        if (k < int'(rx_got)) begin
          if (narrow)     rd_next[8*k +: 8]   = rx_mem[rx_rp + AW'(k)][7:0];
          else if (k < 2) rd_next[16*k +: 16] = rx_mem[rx_rp + AW'(k)][15:0];
        end
    end
  end

  always_ff @(posedge clk)
    if (rx_ok) rx_mem[rx_wp] <= {rx_cs, rx_item & mask};

  always_ff @(posedge clk)
    if (!rst_n) begin
      rx_wp    <= '0;
      rx_rp    <= '0;
      rx_cnt   <= '0;
      rd_data  <= '0;
      overrun  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (rx_ok) rx_wp <= rx_wp + AW'(1);
      if (rx_rd) begin
        rd_data <= rd_next;
        rx_rp   <= rx_rp + AW'(rx_got);
        if (rx_got < rx_req) underrun <= 1'b1;
      end
      rx_cnt <= rx_cnt + (rx_ok ? LW'(1) : LW'(0)) - (rx_rd ? LW'(rx_got) : LW'(0));
      if ((tx_wr && !tx_fit) || (rx_push && !rx_ok)) overrun <= 1'b1;
    end

  assign rx_level = rx_cnt;

  // R12
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));

  // R4
  tx_full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_strb != 4'h0) && (tx_level == LW'(DEPTH)) && !tx_pop
    |=> overrun && $stable(tx_level));

  // R3
  tx_pair_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && tx_multi && (wr_strb == 4'hF) && (int'(tx_level) + 2 <= DEPTH) && !tx_pop
    |=> tx_level == $past(tx_level) + LW'(2));

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (rd_strb != 4'h0) && (rx_level == '0) |=> underrun && (rd_data == 32'h0));

  // R7
  master_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (rd_strb != 4'h0) && master && !rx_push
    |=> (rx_level == $past(rx_level) - LW'(($past(rx_level) != '0) ? 1 : 0))
        && (rd_data[31:16+CSW] == '0));

  // R11
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun |=> overrun) and (underrun |=> underrun));
endmodule

// File: tb/sim_spi_fifo_front.sv
module sim_spi_fifo_front;
  localparam int DEPTH = 4;
  localparam int CSW   = 4;
  localparam int LW    = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst_n;
  logic [4:0] cfg_width;
  logic tx_multi, rx_multi, master;
  logic wr_en, rd_en, tx_pop, rx_push;
  logic [3:0] wr_strb, rd_strb;
  logic [31:0] wr_data, rd_data;
  logic tx_valid, overrun, underrun;
  logic [15:0] tx_item, rx_item;
  logic [CSW-1:0] rx_cs;
  logic [LW-1:0] tx_level, rx_level;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  spi_fifo_front #(.DEPTH(DEPTH), .CSW(CSW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .tx_multi(tx_multi),
    .rx_multi(rx_multi), .master(master), .wr_en(wr_en), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_en(rd_en), .rd_strb(rd_strb), .rd_data(rd_data),
    .tx_valid(tx_valid), .tx_item(tx_item), .tx_pop(tx_pop), .rx_push(rx_push),
    .rx_item(rx_item), .rx_cs(rx_cs), .tx_level(tx_level), .rx_level(rx_level),
    .overrun(overrun), .underrun(underrun));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] w, input logic tm, input logic rm, input logic ms);
    rst_n = 1'b0; wr_en = 0; rd_en = 0; tx_pop = 0; rx_push = 0;
    wr_strb = 0; rd_strb = 0; wr_data = 0; rx_item = 0; rx_cs = 0;
    cfg_width = w; tx_multi = tm; rx_multi = rm; master = ms;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    wr_en = 1; wr_strb = s; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_strb = 0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] d);
    rd_en = 1; rd_strb = s;
    @(negedge clk);
    rd_en = 0; rd_strb = 0;
    d = rd_data;
  endtask

  task automatic feed(input logic [15:0] it, input logic [CSW-1:0] cs);
    rx_push = 1; rx_item = it; rx_cs = cs;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic pop(output logic [15:0] it);
    it = tx_item;
    tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
  endtask

  task automatic t_reset;
    do_reset(5'd16, 0, 0, 0);
    check("R13 tx_level", 32'(tx_level), 0);
    check("R13 rx_level", 32'(rx_level), 0);
    check("R13 flags", {30'd0, overrun, underrun}, 0);
    check("R13 tx_valid", 32'(tx_valid), 0);
    check("R13 rd_data", rd_data, 0);
  endtask

  task automatic t_single_tx;
    logic [15:0] it;
    do_reset(5'd16, 0, 0, 0);
    wr(4'hF, 32'hBEEF_1234);
    check("R2 level after full-strobe write", 32'(tx_level), 1);
    wr(4'h3, 32'h0000_5678);
    wr(4'h0, 32'h0000_9999);
    check("R2 zero strobe ignored", 32'(tx_level), 2);
    check("R5 tx_valid", 32'(tx_valid), 1);
    pop(it); check("R5 first item", 32'(it), 32'h1234);
    pop(it); check("R5 second item", 32'(it), 32'h5678);
    check("R5 empty after pops", {31'd0, tx_valid}, 0);
    tx_pop = 1; @(negedge clk); tx_pop = 0;
    check("R2 pop on empty ignored", 32'(tx_level), 0);
  endtask

  task automatic t_multi_tx;
    logic [15:0] it;
    do_reset(5'd8, 1, 0, 0);
    wr(4'hF, 32'h11AB_22CD);
    check("R3 two items pushed", 32'(tx_level), 2);
    wr(4'h3, 32'hFFFF_0077);
    check("R3 partial strobe one item", 32'(tx_level), 3);
    pop(it); check("R3 low half first (masked R1)", 32'(it), 32'h00CD);
    pop(it); check("R3 high half second (masked R1)", 32'(it), 32'h00AB);
    pop(it); check("R3 partial item", 32'(it), 32'h0077);
  endtask

  task automatic t_tx_overrun;
    logic [15:0] it;
    do_reset(5'd16, 1, 0, 0);
    wr(4'hF, 32'h2222_1111);
    wr(4'hF, 32'h4444_3333);
    check("R12 level at depth", 32'(tx_level), 4);
    check("R4 no overrun yet", 32'(overrun), 0);
    wr(4'h3, 32'h0000_5555);
    check("R4 rejected when full", 32'(tx_level), 4);
    check("R4 overrun set", 32'(overrun), 1);
    pop(it); check("R5 order 1", 32'(it), 32'h1111);
    wr(4'hF, 32'h7777_6666);
    check("R4 pair rejected with one slot", 32'(tx_level), 3);
    wr(4'h3, 32'h0000_8888);
    check("R4 single accepted", 32'(tx_level), 4);
    pop(it); check("R5 order 2", 32'(it), 32'h2222);
    pop(it); check("R5 order 3", 32'(it), 32'h3333);
    pop(it); check("R5 order 4", 32'(it), 32'h4444);
    pop(it); check("R4 no partial push", 32'(it), 32'h8888);
  endtask

  task automatic t_simul;
    do_reset(5'd16, 0, 0, 0);
    wr(4'h3, 32'h0000_0001);
    wr_en = 1; wr_strb = 4'h3; wr_data = 32'h2; tx_pop = 1;
    @(negedge clk);
    wr_en = 0; wr_strb = 0; tx_pop = 0;
    check("R12 push+pop same cycle", 32'(tx_level), 1);
    check("R12 survivor", 32'(tx_item), 32'h0002);
  endtask

  task automatic t_single_rx;
    logic [31:0] d;
    do_reset(5'd16, 0, 0, 0);
    feed(16'hA5C3, 4'h5);
    feed(16'h0012, 4'hA);
    check("R12 rx_level", 32'(rx_level), 2);
    rd(4'hF, d); check("R6 item+cs", d, 32'h0005_A5C3);
    check("R6 one popped", 32'(rx_level), 1);
    rd(4'h3, d); check("R6 second item+cs", d, 32'h000A_0012);
  endtask

  task automatic t_master_rx;
    logic [31:0] d;
    do_reset(5'd8, 0, 1, 1);
    feed(16'h0033, 4'h2);
    feed(16'h0044, 4'h3);
    rd(4'hF, d); check("R7 master forces single", d, 32'h0002_0033);
    check("R7 one popped", 32'(rx_level), 1);
  endtask

  task automatic t_multi8;
    logic [31:0] d;
    do_reset(5'd8, 0, 1, 0);
    feed(16'h0011, 4'h7); feed(16'h0022, 4'h7); feed(16'h0033, 4'h7); feed(16'h0044, 4'h7);
    rd(4'hF, d); check("R8 four bytes", d, 32'h4433_2211);
    check("R8 all popped", 32'(rx_level), 0);
    feed(16'h0055, 4'h1); feed(16'h0066, 4'h1); feed(16'h01F7, 4'h1);
    rd(4'h3, d); check("R8 two bytes", d, 32'h0000_6655);
    rd(4'h1, d); check("R8 one byte masked R1", d, 32'h0000_00F7);
    check("R8 no underrun", 32'(underrun), 0);
  endtask

  task automatic t_multi16;
    logic [31:0] d;
    do_reset(5'd12, 0, 1, 0);
    feed(16'hFABC, 4'h1); feed(16'h0123, 4'h1); feed(16'h0456, 4'h1);
    rd(4'hF, d); check("R9 two halfwords masked R1", d, 32'h0123_0ABC);
    check("R9 level", 32'(rx_level), 1);
    rd(4'h3, d); check("R9 one halfword", d, 32'h0000_0456);
  endtask

  task automatic t_underrun;
    logic [31:0] d;
    do_reset(5'd16, 0, 0, 0);
    rd(4'hF, d);
    check("R10 empty read zero", d, 0);
    check("R10 underrun set", 32'(underrun), 1);
    do_reset(5'd8, 0, 1, 0);
    feed(16'h00AA, 4'h0); feed(16'h00BB, 4'h0);
    rd(4'hF, d);
    check("R10 partial packed read", d, 32'h0000_BBAA);
    check("R10 partial sets underrun", 32'(underrun), 1);
    check("R10 level empty", 32'(rx_level), 0);
  endtask

  task automatic t_rx_full;
    logic [31:0] d;
    do_reset(5'd16, 0, 0, 0);
    for (int i = 1; i <= 5; i++) feed(16'(i), 4'h0);
    check("R11 level capped", 32'(rx_level), 4);
    check("R11 overrun set", 32'(overrun), 1);
    rd(4'hF, d); rd(4'hF, d); rd(4'hF, d); rd(4'hF, d);
    check("R11 last kept item", d, 32'h0000_0004);
    check("R11 fifth dropped", 32'(rx_level), 0);
  endtask

  task automatic t_clamp;
    logic [15:0] it;
    do_reset(5'd5, 0, 0, 0);
    wr(4'h3, 32'h0000_01FF);
    pop(it); check("R1 low clamp to 8", 32'(it), 32'h00FF);
    do_reset(5'd20, 0, 0, 0);
    wr(4'h3, 32'h0000_FFFF);
    pop(it); check("R1 high clamp to 16", 32'(it), 32'hFFFF);
  endtask

  initial begin
    t_reset;
    t_single_tx;
    t_multi_tx;
    t_tx_overrun;
    t_simul;
    t_single_rx;
    t_master_rx;
    t_multi8;
    t_multi16;
    t_underrun;
    t_rx_full;
    t_clamp;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule